// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a synchronous DRAM from reset until the memory can accept normal traffic. After reset it holds the bus in a quiet state for a settling interval derived from the clock frequency. Next it closes every bank with a single precharge-all command. It then runs a group of auto-refresh commands and one mode-register load, in an order chosen by a parameter, with the required gaps of idle cycles between commands.

The mode operand comes from a parameter word. Bits that the memory reserves are forced to zero before the word reaches the address pins. When the last gap has elapsed, a ready flag rises and stays high until the next reset. A memory controller uses that flag to hand the bus over to its normal scheduler.

Top module: `sdram_init_seq`

## Requirements
- R1: Counting the cycle in which reset is first sampled low as cycle 0, cycles 0 to SETTLE_CYC-1 (SETTLE_CYC = SETTLE_US x CLK_MHZ) drive cke=1, dqm=1, a NOP command, bank 0, address 0 and ready=0.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, precharge=0010, auto-refresh=0001 and mode-register load=0000.
- R3: In cycle SETTLE_CYC exactly one precharge is issued, with address bit 10 set, all other address bits 0 and bank 0.
- R4: Exactly max(REF_COUNT,2) auto-refresh commands are issued, each with address 0 and bank 0, spaced T_RC cycles apart.
- R5: The mode-register load drives MODE_WORD onto the address pins with bits 7, 8 and 11 (and any bit at 12 or above) cleared, and bank 0.
- R6: With MODE_FIRST=0 the order is precharge, refreshes, mode load. With MODE_FIRST=1 it is precharge, mode load, refreshes.
- R7: The command after a precharge comes T_RP cycles later, the one after a refresh T_RC cycles later and the one after a mode load 2 cycles later. Every cycle in between carries a NOP with dqm=1.
- R8: Ready rises in the cycle that is one gap after the last command and stays high until reset. While ready is high the bus carries NOP with cke=1 and dqm=0.
- R9: A synchronous active-high reset, asserted at any point, returns all outputs to the state of cycle 0 of R1 and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_dqm | output | 1 | Data mask, high during initialization |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank address |
| mem_addr | output | ROW_W | Address bus |
| init_ready | output | 1 | Initialization complete |

## Verification
The only inputs are the clock and reset, so the assertions assume nothing more than a reset that may arrive in any cycle, including partway through the settling count or a wait gap. The stimulus releases reset after a random hold. It then lets each run last a random length, which cuts the sequence short at arbitrary points. Directed runs long enough for two parameter sets to reach ready check the full order and spacing of the commands.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_WAIT,
    ST_READY
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_t;

  function automatic int unsigned settle_cycles(input int unsigned mhz, input int unsigned us);
    int unsigned n;
    n = mhz * us;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // Clears the reserved and test-mode positions of the mode operand.
  function automatic logic [31:0] clean_mode(input logic [31:0] w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 12; i++) begin
      if (i != 7 && i != 8 && i != 11) r[i] = w[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= CNT_W'(INIT_VAL);
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned REFS       = 2,
  parameter int unsigned GAP_RP     = 3,
  parameter int unsigned GAP_RC     = 9,
  parameter int unsigned GAP_MRD    = 2,
  parameter bit          MODE_FIRST = 1'b0,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_done,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output seq_state_t       state,
  output logic             cmd_issue,
  output logic             ready
);

  localparam int unsigned RL_W = $clog2(REFS + 1);
  localparam seq_state_t AFTER_PRE  = MODE_FIRST ? ST_MRS : ST_REF;
  localparam seq_state_t AFTER_MRS  = MODE_FIRST ? ST_REF : ST_READY;
  localparam seq_state_t AFTER_REFS = MODE_FIRST ? ST_READY : ST_MRS;

  seq_state_t      after_q;
  logic [RL_W-1:0] ref_left_q;
  logic            last_ref;

  assign last_ref   = (ref_left_q == RL_W'(1));
  assign cmd_issue  = (state == ST_PRE) || (state == ST_REF) || (state == ST_MRS);
  assign timer_load = cmd_issue;
  assign ready      = (state == ST_READY);

  always_comb begin
    unique case (state)
      ST_PRE:  timer_val = CNT_W'(GAP_RP - 2);
      ST_REF:  timer_val = CNT_W'(GAP_RC - 2);
      ST_MRS:  timer_val = CNT_W'(GAP_MRD - 2);
      default: timer_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SETTLE;
      after_q    <= ST_PRE;
      ref_left_q <= RL_W'(REFS);
    end else begin
      unique case (state)
        ST_SETTLE: if (wait_done) state <= ST_PRE;
        ST_PRE: begin
          state   <= ST_WAIT;
          after_q <= AFTER_PRE;
        end
        ST_REF: begin
          state      <= ST_WAIT;
          ref_left_q <= ref_left_q - 1'b1;
          after_q    <= last_ref ? AFTER_REFS : ST_REF;
        end
        ST_MRS: begin
          state   <= ST_WAIT;
          after_q <= AFTER_MRS;
        end
        ST_WAIT:  if (wait_done) state <= after_q;
        default:  state <= ST_READY;
      endcase
    end
  end

  assert_refs_used_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (ref_left_q == '0));

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_gap_nop_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_issue |=> !cmd_issue);

endmodule

// File: rtl/sdram_init_drive.sv
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BANK_W = 2
) (
  input  seq_state_t        state,
  input  logic [ROW_W-1:0]  mode_operand,
  output logic              cke,
  output logic              dqm,
  output sdram_cmd_t        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr
);

  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1) << 10;

  assign cke = 1'b1;
  assign ba  = '0;
  assign dqm = (state != ST_READY);

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    unique case (state)
      ST_PRE: begin
        cmd  = CMD_PRE;
        addr = ALL_BANKS;
      end
      ST_REF:  cmd = CMD_REF;
      ST_MRS: begin
        cmd  = CMD_MRS;
        addr = mode_operand;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 50,
  parameter int unsigned SETTLE_US  = 200,
  parameter int unsigned REF_COUNT  = 2,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_RC       = 9,
  parameter bit          MODE_FIRST = 1'b0,
  parameter int unsigned ROW_W      = 12,
  parameter int unsigned BANK_W     = 2,
  parameter logic [31:0] MODE_WORD  = 32'h0000_0232
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_cke,
  output logic              mem_dqm,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ROW_W-1:0]  mem_addr,
  output logic              init_ready
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
  localparam int unsigned REFS       = at_least(REF_COUNT, 2);
  localparam int unsigned GAP_RP     = at_least(T_RP, 2);
  localparam int unsigned GAP_RC     = at_least(T_RC, 2);
  localparam int unsigned GAP_MRD    = 2;
  localparam int unsigned MAX_CNT    = at_least(at_least(SETTLE_CYC, GAP_RP), GAP_RC);
  localparam int unsigned CNT_W      = at_least($clog2(MAX_CNT + 1), 1);
  localparam logic [31:0] MODE_CLEAN = clean_mode(MODE_WORD);

  seq_state_t       state;
  sdram_cmd_t       cmd;
  logic             wait_done;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             cmd_issue;
  logic             in_settle;

  sdram_init_timer #(
    .CNT_W   (CNT_W),
    .INIT_VAL(SETTLE_CYC - 1)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .load_val(timer_val),
    .expired (wait_done)
  );

  sdram_init_fsm #(
    .REFS      (REFS),
    .GAP_RP    (GAP_RP),
    .GAP_RC    (GAP_RC),
    .GAP_MRD   (GAP_MRD),
    .MODE_FIRST(MODE_FIRST),
    .CNT_W     (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .wait_done (wait_done),
    .timer_load(timer_load),
    .timer_val (timer_val),
    .state     (state),
    .cmd_issue (cmd_issue),
    .ready     (init_ready)
  );

  sdram_init_drive #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W)
  ) drive_i (
    .state       (state),
    .mode_operand(MODE_CLEAN[ROW_W-1:0]),
    .cke         (mem_cke),
    .dqm         (mem_dqm),
    .cmd         (cmd),
    .ba          (mem_ba),
    .addr        (mem_addr)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
  assign in_settle = (state == ST_SETTLE);

  assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    in_settle |-> (mem_cke && mem_dqm && cmd == CMD_NOP && !init_ready));

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (mem_addr[10] && $countones(mem_addr) == 1));

  assert_mode_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MRS) |-> (!mem_addr[7] && !mem_addr[8] && !mem_addr[11] && mem_ba == '0));

  assert_reset_restart_R9: assert property (@(posedge clk)
    rst |=> (in_settle && !init_ready));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  // parameter set A (defaults)
  localparam int A_SETTLE = 10000;
  localparam int A_NREF = 2, A_TRP = 3, A_TRC = 9;
  localparam bit A_MF = 1'b0;
  localparam logic [11:0] A_MW = 12'h232;
  // parameter set B
  localparam int B_SETTLE = 50;
  localparam int B_NREF = 3, B_TRP = 2, B_TRC = 4;
  localparam bit B_MF = 1'b1;
  localparam logic [11:0] B_MW = 12'hFFF;

  logic a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_rdy;
  logic [1:0] a_ba;
  logic [11:0] a_addr;
  logic b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_rdy;
  logic [1:0] b_ba;
  logic [11:0] b_addr;

  sdram_init_seq dut_i (
    .clk(clk), .rst(rst), .mem_cke(a_cke), .mem_dqm(a_dqm), .mem_cs_n(a_cs),
    .mem_ras_n(a_ras), .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_ba(a_ba),
    .mem_addr(a_addr), .init_ready(a_rdy)
  );

  sdram_init_seq #(
    .CLK_MHZ(50), .SETTLE_US(1), .REF_COUNT(3), .T_RP(2), .T_RC(4),
    .MODE_FIRST(1'b1), .MODE_WORD(32'h0000_0FFF)
  ) dut_b (
    .clk(clk), .rst(rst), .mem_cke(b_cke), .mem_dqm(b_dqm), .mem_cs_n(b_cs),
    .mem_ras_n(b_ras), .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_ba(b_ba),
    .mem_addr(b_addr), .init_ready(b_rdy)
  );

  int n_checks = 0;
  int n_fail = 0;
  int total_cyc = 0;
  bit finished = 1'b0;

  // Reserved positions 7, 8 and 11 zeroed.
  function automatic logic [11:0] bench_mode(input logic [11:0] w);
    return w & 12'h67F;
  endfunction

  // Expected {cke, ready, dqm, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[11:0]}
  function automatic logic [20:0] expect_at(input int c, input int settle, input int nref,
                                             input int trp, input int trc, input bit mf,
                                             input logic [11:0] mw, output string tag);
    int t, r0, mrs, rdy;
    logic [20:0] nop;
    nop = {1'b1, 1'b0, 1'b1, 4'b0111, 2'b00, 12'h000};
    tag = "R7";
    if (c < settle) begin tag = "R1"; return nop; end
    if (c == settle) begin tag = "R3"; return {1'b1, 1'b0, 1'b1, 4'b0010, 2'b00, 12'h400}; end
    t = settle + trp;
    if (mf) begin mrs = t; r0 = t + 2; rdy = r0 + nref * trc; end
    else begin r0 = t; mrs = t + nref * trc; rdy = mrs + 2; end
    if (c >= rdy) begin tag = "R8"; return {1'b1, 1'b1, 1'b0, 4'b0111, 2'b00, 12'h000}; end
    if (c == mrs) begin tag = "R5"; return {1'b1, 1'b0, 1'b1, 4'b0000, 2'b00, bench_mode(mw)}; end
    if (c >= r0 && ((c - r0) % trc) == 0 && ((c - r0) / trc) < nref) begin
      tag = "R4"; return {1'b1, 1'b0, 1'b1, 4'b0001, 2'b00, 12'h000};
    end
    return nop;
  endfunction

  task automatic check_one(input string nm, input int c, input logic [20:0] act,
                           input logic [20:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (with R2 R6 R9) %s cycle %0d: actual %h expected %h", tag, nm, c, act, exp);
    end
  endtask

  task automatic check_cycle(input int c);
    string ta, tb;
    logic [20:0] ea, eb;
    ea = expect_at(c, A_SETTLE, A_NREF, A_TRP, A_TRC, A_MF, A_MW, ta);
    eb = expect_at(c, B_SETTLE, B_NREF, B_TRP, B_TRC, B_MF, B_MW, tb);
    check_one("A", c, {a_cke, a_rdy, a_dqm, a_cs, a_ras, a_cas, a_we, a_ba, a_addr}, ea, ta);
    check_one("B", c, {b_cke, b_rdy, b_dqm, b_cs, b_ras, b_cas, b_we, b_ba, b_addr}, eb, tb);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", total_cyc);
      finish_run();
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    for (int ep = 0; ep < 24; ep++) begin
      int hold, len;
      @(negedge clk);
      rst = 1'b1;
      hold = 1 + int'($urandom % 3);
      repeat (hold) @(negedge clk);
      rst = 1'b0;  // cycle 0: reset restart checked (R9)
      if (ep == 0 || ep == 12 || ep == 23) len = A_SETTLE + 40;  // full run, set A reaches ready
      else if (ep == 1) len = 120;                                // full run, set B
      else len = 1 + int'($urandom % 200);                        // truncated by reset
      for (int c = 0; c < len; c++) begin
        check_cycle(c);
        @(negedge clk);
      end
    end
    finish_run();
  end

endmodule